// File: doc/BRIEF.md
# Receive Channel Address Classifier

This block sits after destination-address extraction in an Ethernet receive path and decides which of eight receive queues a frame belongs to. Each queue owns a programmable 48-bit station address and an enable bit, so one physical port behaves as eight separate virtual stations. Traffic that no station claims falls into a small set of special classes. These classes are broadcast, multicast, and frames that are erroneous or unmatched. Each class can be switched on and sent to a channel of its choice.

The receive datapath presents the destination address, together with an error flag, on a one-cycle strobe. One clock later the block returns a channel number, an accept/drop flag and a valid pulse. Station addresses are loaded through a simple write port, one channel per write. The class enables and class channels are static configuration inputs.

Top module: `rx_chan_classifier`

## Requirements
- R1: After reset, `dec_valid` is 0, every station address is zero, and every station enable is cleared.
- R2: A `cfg_wr` pulse stores `cfg_mac` and `cfg_en` for channel `cfg_sel`. The new values govern any strobe from the next cycle on.
- R3: A strobe whose destination is all ones and whose `frm_err` is 0 counts as broadcast. When `bc_en` is 1 it is accepted on channel `bc_chan`.
- R4: A strobe whose destination is not all ones, whose first byte has bit 0 set (`dst_mac[40]`) and whose `frm_err` is 0 counts as multicast. When `mc_en` is 1 it is accepted on channel `mc_chan`.
- R5: A good, non-multicast destination that equals the stored address of an enabled channel is accepted on that channel. A disabled channel never matches.
- R6: When several enabled channels hold the matching address, the lowest-numbered of them is chosen.
- R7: A strobe with `frm_err` set is accepted on `pr_chan` when `pr_en` is 1, and is dropped otherwise, whatever its address.
- R8: An unmatched unicast, a broadcast with `bc_en` clear, or a multicast with `mc_en` clear goes to `pr_chan` when `pr_en` is 1. Otherwise it is dropped. A drop shows `dec_accept`=0 and `dec_chan`=0.
- R9: `dec_valid` is high in exactly the cycle after each `dst_valid` cycle. Decisions use the configuration inputs sampled together with the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Station-address write strobe |
| cfg_sel | input | 3 | Channel being written |
| cfg_mac | input | 48 | Station address to store |
| cfg_en | input | 1 | Enable bit to store for that channel |
| bc_en | input | 1 | Accept broadcast frames |
| bc_chan | input | 3 | Channel for broadcast frames |
| mc_en | input | 1 | Accept multicast frames |
| mc_chan | input | 3 | Channel for multicast frames |
| pr_en | input | 1 | Accept unmatched and error frames |
| pr_chan | input | 3 | Channel for unmatched and error frames |
| dst_valid | input | 1 | Destination address strobe |
| dst_mac | input | 48 | Destination address, first byte in bits 47:40 |
| frm_err | input | 1 | Frame carries an error |
| dec_valid | output | 1 | Decision valid |
| dec_chan | output | 3 | Chosen channel |
| dec_accept | output | 1 | 1 = deliver, 0 = drop |

## Verification
The station-match assertion assumes that no address write lands in the same cycle as a strobe. The bench never overlaps the two: every write completes a full cycle before the next strobe. The assertions also treat the class configuration as valid in the strobe cycle only. The bench changes it solely between strobes, holding it steady through each sweep point. Sweeps cover every class-enable combination, both error states and a destination hitting every channel, with the expected decision worked out in a bench model.

// File: rtl/rx_chan_classifier.sv
module rx_chan_classifier #(
  parameter int NUM_CH = 8,
  parameter int MAC_W  = 48
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_wr,
  input  logic [$clog2(NUM_CH)-1:0] cfg_sel,
  input  logic [MAC_W-1:0]          cfg_mac,
  input  logic                      cfg_en,
  input  logic                      bc_en,
  input  logic [$clog2(NUM_CH)-1:0] bc_chan,
  input  logic                      mc_en,
  input  logic [$clog2(NUM_CH)-1:0] mc_chan,
  input  logic                      pr_en,
  input  logic [$clog2(NUM_CH)-1:0] pr_chan,
  input  logic                      dst_valid,
  input  logic [MAC_W-1:0]          dst_mac,
  input  logic                      frm_err,
  output logic                      dec_valid,
  output logic [$clog2(NUM_CH)-1:0] dec_chan,
  output logic                      dec_accept
);
  localparam int CH_W   = $clog2(NUM_CH);
  localparam int MC_BIT = MAC_W - 8;

  logic [MAC_W-1:0] sta_mac [NUM_CH];
  logic [NUM_CH-1:0] sta_en;
  logic [NUM_CH-1:0] hit;
  logic [CH_W-1:0]   hit_ch;
  logic              any_hit;
  logic              is_bc, is_mc;
  logic              nx_acc;
  logic [CH_W-1:0]   nx_ch;

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_sta
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          sta_mac[g] <= '0;
          sta_en[g]  <= 1'b0;
        end else if (cfg_wr && cfg_sel == CH_W'(g)) begin
          sta_mac[g] <= cfg_mac;
          sta_en[g]  <= cfg_en;
        end
      end
      assign hit[g] = sta_en[g] && (sta_mac[g] == dst_mac);
    end
  endgenerate

  always_comb begin
    hit_ch = '0;
    for (int i = NUM_CH - 1; i >= 0; i--)
      if (hit[i]) hit_ch = CH_W'(i);
  end

  assign any_hit = |hit;
  assign is_bc   = &dst_mac;
  assign is_mc   = dst_mac[MC_BIT] && !is_bc;

  always_comb begin
    nx_acc = 1'b0;
    nx_ch  = '0;
    if (frm_err) begin
      nx_acc = pr_en;
      nx_ch  = pr_chan;
    end else if (is_bc && bc_en) begin
      nx_acc = 1'b1;
      nx_ch  = bc_chan;
    end else if (is_mc && mc_en) begin
      nx_acc = 1'b1;
      nx_ch  = mc_chan;
    end else if (!is_bc && !is_mc && any_hit) begin
      nx_acc = 1'b1;
      nx_ch  = hit_ch;
    end else begin
      nx_acc = pr_en;
      nx_ch  = pr_chan;
    end
    if (!nx_acc) nx_ch = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_chan   <= '0;
    end else begin
      dec_valid <= dst_valid;
      if (dst_valid) begin
        dec_accept <= nx_acc;
        dec_chan   <= nx_ch;
      end
    end
  end

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    dst_valid |=> dec_valid);
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !dst_valid |=> !dec_valid);
  a_r3_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && (&dst_mac) && !frm_err && bc_en) |=>
      (dec_accept && dec_chan == $past(bc_chan)));
  a_r4_multicast: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && dst_mac[MC_BIT] && !(&dst_mac) && !frm_err && mc_en) |=>
      (dec_accept && dec_chan == $past(mc_chan)));
  a_r7_error_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && frm_err && !pr_en) |=> (!dec_accept && dec_chan == '0));
  a_r8_drop_needs_no_prom: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_accept) |-> !$past(pr_en));
  a_r5_station_match: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_accept && !$past(cfg_wr) && !$past(frm_err) &&
     !$past(dst_mac[MC_BIT]) && !$past(pr_en)) |->
      (sta_en[dec_chan] && sta_mac[dec_chan] == $past(dst_mac)));
endmodule

// File: tb/test_rx_chan_classifier.sv
module test_rx_chan_classifier;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_wr = 0;
  logic [2:0]  cfg_sel = 0;
  logic [47:0] cfg_mac = 0;
  logic        cfg_en = 0;
  logic        bc_en = 0, mc_en = 0, pr_en = 0;
  logic [2:0]  bc_chan = 0, mc_chan = 0, pr_chan = 0;
  logic        dst_valid = 0;
  logic [47:0] dst_mac = 0;
  logic        frm_err = 0;
  logic        dec_valid, dec_accept;
  logic [2:0]  dec_chan;

  int checks = 0, fails = 0;
  logic [47:0] m_mac [8];
  logic [7:0]  m_en;

  rx_chan_classifier i_rx_chan_classifier (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int ch, input logic [47:0] mac, input logic en);
    @(negedge clk);
    cfg_wr = 1; cfg_sel = 3'(ch); cfg_mac = mac; cfg_en = en;
    m_mac[ch] = mac; m_en[ch] = en;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  function automatic logic [3:0] model(input logic [47:0] a, input logic err);
    logic bc, mc;
    bc = &a;
    mc = a[40] && !bc;
    if (err) return pr_en ? {1'b1, pr_chan} : 4'h0;
    if (bc && bc_en) return {1'b1, bc_chan};
    if (mc && mc_en) return {1'b1, mc_chan};
    if (!bc && !mc)
      for (int i = 0; i < 8; i++)
        if (m_en[i] && m_mac[i] == a) return {1'b1, 3'(i)};
    return pr_en ? {1'b1, pr_chan} : 4'h0;
  endfunction

  task automatic probe(input string req, input logic [47:0] a, input logic err);
    logic [3:0] exp;
    exp = model(a, err);
    dst_valid = 1; dst_mac = a; frm_err = err;
    @(negedge clk);
    dst_valid = 0;
    chk("R9", {3'b0, dec_valid}, 4'h1);
    chk(req, {dec_accept, dec_chan}, exp);
    @(negedge clk);
    chk("R9", {3'b0, dec_valid}, 4'h0);
  endtask

  initial begin
    m_en = '0;
    for (int i = 0; i < 8; i++) m_mac[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1", {3'b0, dec_valid}, 4'h0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", {3'b0, dec_valid}, 4'h0);
    // R1: all enables clear after reset, so a zero address is unmatched
    probe("R1", 48'h0, 1'b0);

    for (int i = 0; i < 8; i++) wr(i, {40'h02_00_00_00_10, 8'(i)}, i != 7);

    for (int cfg = 0; cfg < 8; cfg++) begin
      @(negedge clk);
      bc_en = cfg[0]; mc_en = cfg[1]; pr_en = cfg[2];
      bc_chan = 3'(cfg); mc_chan = 3'(7 - cfg); pr_chan = 3'((cfg + 3) % 8);
      for (int e = 0; e < 2; e++) begin
        for (int p = 0; p < 8; p++)
          probe(e ? "R7" : (p == 7 ? "R8" : "R5"), {40'h02_00_00_00_10, 8'(p)}, e[0]);
        probe(e ? "R7" : "R3", 48'hFFFF_FFFF_FFFF, e[0]);
        probe(e ? "R7" : "R4", 48'h01_00_5E_00_00_01, e[0]);
        probe(e ? "R7" : "R8", 48'h02_AA_BB_CC_DD_EE, e[0]);
      end
    end

    bc_en = 0; mc_en = 0; pr_en = 0;
    wr(5, 48'h02_00_00_00_10_02, 1'b1);
    probe("R6", 48'h02_00_00_00_10_02, 1'b0);
    wr(2, 48'h02_00_00_00_10_02, 1'b0);
    probe("R5", 48'h02_00_00_00_10_02, 1'b0);
    wr(7, 48'h02_12_34_56_78_9A, 1'b1);
    probe("R2", 48'h02_12_34_56_78_9A, 1'b0);
    probe("R2", 48'h02_00_00_00_10_07, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule